// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block puts a four-bank, 32-bit SDRAM to sleep and wakes it up again. It does this by driving the device's command pins and clock enable. When the controller raises `enter_req` in the idle state, the sequencer first issues a burst of auto-refresh commands. It then issues the self-refresh entry command, which is the refresh pattern with the clock enable dropped in the same cycle. While the memory sleeps, every command pin is parked at deselect with the data mask high, and the clock enable stays low for as long as no exit has been requested.

Wake-up starts when `exit_req` is seen after a minimum residency in self-refresh. The sequencer waits for `clk_stable` and then raises the clock enable while keeping chip select inactive for a full row-cycle time. It then issues a second auto-refresh burst. `sr_active` covers the whole stretch from the entry command to the end of the second burst, and a one-cycle `sr_done` pulse closes the sequence.

The states are IDLE, PRE_REF_BURST, SR_ENTER, SR_HOLD, WAIT_CLK, EXIT_RECOVER, POST_REF_BURST and DONE. The transitions are:
- IDLE→PRE_REF_BURST on `enter_req`.
- PRE_REF_BURST→SR_ENTER when the burst and its trailing gap are spent.
- SR_ENTER→SR_HOLD unconditionally.
- SR_HOLD→WAIT_CLK when the residency timer has expired and `exit_req` is high.
- WAIT_CLK→EXIT_RECOVER on `clk_stable`.
- EXIT_RECOVER→POST_REF_BURST after the recovery time.
- POST_REF_BURST→DONE when the burst and its trailing gap are spent.
- DONE→IDLE unconditionally.

Parameters: `T_RC` (row-cycle time in clocks, default 7), `T_RAS` (minimum residency in clocks, default 5) and `REF_COUNT` (refreshes per burst, default 4096).

Top module: `sdram_sr_seq`

## Requirements
- R1: The entry command drives cs_n=0, ras_n=0, cas_n=0, we_n=1 in the same cycle that cke first goes 0, and `enter_ack` is 1 in exactly that cycle.
- R2: In every cycle after the entry command while cke is 0, the pins are parked at deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1) with dqm=1.
- R3: cke is never raised unless `exit_req` was seen high while cke was low. `enter_req` outside IDLE and `exit_req` outside SR_HOLD have no effect.
- R4: cke stays 0 in WAIT_CLK until `clk_stable` is sampled high. It rises in the cycle after that sample.
- R5: From the cycle cke rises, cs_n stays 1 for T_RC cycles. `exit_ack` is 1 in the first cycle cke is high again.
- R6: cke stays low for at least T_RAS cycles after the entry command. If `exit_req` is high from the start, cke rises T_RAS+2 cycles after the entry command.
- R7: Each burst issues exactly REF_COUNT auto-refreshes (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1), spaced exactly T_RC cycles apart, with NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) in between. The first one comes in the cycle after `enter_req` is accepted.
- R8: The entry command comes T_RC+1 cycles after the last pre-entry auto-refresh.
- R9: The first post-exit auto-refresh comes T_RC cycles after cke rises.
- R10: `sr_active` is 1 from the entry command through the cycle before `sr_done`. `sr_done` is a one-cycle pulse T_RC+1 cycles after the last post-exit auto-refresh, with `sr_active` 0 during the pulse.
- R11: During and after reset, the outputs show IDLE: cke=1, NOP on the pins, dqm=1, and all status outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter self-refresh (taken in IDLE) |
| exit_req | input | 1 | Request to leave self-refresh (taken in SR_HOLD) |
| clk_stable | input | 1 | System clock running and stable |
| enter_ack | output | 1 | Pulse in the entry-command cycle |
| exit_ack | output | 1 | Pulse in the first cycle cke is high again |
| sr_active | output | 1 | Sequence holds the device in or near self-refresh |
| sr_done | output | 1 | One-cycle pulse at the end of the post-exit burst |
| sdr_cs_n | output | 1 | SDRAM chip select, active low |
| sdr_ras_n | output | 1 | SDRAM row strobe, active low |
| sdr_cas_n | output | 1 | SDRAM column strobe, active low |
| sdr_we_n | output | 1 | SDRAM write enable, active low |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_dqm | output | 1 | SDRAM data mask |

## Verification
The assertions check the following rules on every cycle:
- the entry encoding on the falling edge of cke;
- the parked pins while asleep;
- that cke rises only after a seen exit request and a stable clock;
- the residency lower bound;
- the deselect window after wake-up;
- the minimum spacing between refreshes;
- the shape of the done pulse.

Only the bench scenarios can show exact cycle placement. That covers the number of refreshes per burst, the T_RC+1 gap before entry, the precise cycle of the cke rise for an early or late exit request and for a late `clk_stable`, and that requests in the wrong state leave the pins untouched.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REF_BURST,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_WAIT_CLK,
        ST_EXIT_RECOVER,
        ST_POST_REF_BURST,
        ST_DONE
    } sr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_DESEL,
        CMD_AREF,
        CMD_SRE
    } sdr_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
        logic dqm;
    } sdr_pins_t;

endpackage

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/sr_ref_counter.sv
module sr_ref_counter #(
    parameter int REF_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic empty
);
    localparam int CW = $clog2(REF_COUNT + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(REF_COUNT);
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign empty = (left_q == '0);
endmodule

// File: rtl/sr_cmd_encode.sv
module sr_cmd_encode
    import sr_seq_pkg::*;
(
    input  sdr_cmd_e  cmd,
    input  logic      cke_on,
    output sdr_pins_t pins
);
    always_comb begin
        pins.cke = cke_on;
        pins.dqm = 1'b1;
        unique case (cmd)
            CMD_NOP:   {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0111;
            CMD_DESEL: {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b1111;
            CMD_AREF:  {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0001;
            CMD_SRE:   {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0001;
        endcase
    end
endmodule

// File: rtl/sdram_sr_seq.sv
module sdram_sr_seq
    import sr_seq_pkg::*;
#(
    parameter int T_RC      = 7,
    parameter int T_RAS     = 5,
    parameter int REF_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    input  logic clk_stable,
    output logic enter_ack,
    output logic exit_ack,
    output logic sr_active,
    output logic sr_done,
    output logic sdr_cs_n,
    output logic sdr_ras_n,
    output logic sdr_cas_n,
    output logic sdr_we_n,
    output logic sdr_cke,
    output logic sdr_dqm
);
    localparam int TMAX = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RC_LOAD  = TW'(T_RC - 1);
    localparam logic [TW-1:0] RAS_LOAD = TW'(T_RAS - 1);

    sr_state_e     cur, nxt;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic [TW-1:0] tmr_count;
    logic          tmr_zero;
    logic          ref_load;
    logic          ref_dec;
    logic          ref_empty;
    sdr_cmd_e      cmd;
    logic          cke_on;
    sdr_pins_t     pins;

    sr_down_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .zero     (tmr_zero)
    );

    sr_ref_counter #(.REF_COUNT(REF_COUNT)) u_refs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ref_load),
        .dec   (ref_dec),
        .empty (ref_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= ST_IDLE;
        end else begin
            cur <= nxt;
        end
    end

    // Transitions and datapath controls
    always_comb begin
        nxt      = cur;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_load = 1'b0;
        ref_dec  = 1'b0;
        unique case (cur)
            ST_IDLE: begin
                if (enter_req) begin
                    nxt      = ST_PRE_REF_BURST;
                    ref_load = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_PRE_REF_BURST, ST_POST_REF_BURST: begin
                if (tmr_zero) begin
                    if (!ref_empty) begin
                        ref_dec  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = RC_LOAD;
                    end else begin
                        nxt = (cur == ST_PRE_REF_BURST) ? ST_SR_ENTER : ST_DONE;
                    end
                end
            end
            ST_SR_ENTER: begin
                nxt      = ST_SR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = RAS_LOAD;
            end
            ST_SR_HOLD: begin
                if (tmr_zero && exit_req) begin
                    nxt = ST_WAIT_CLK;
                end
            end
            ST_WAIT_CLK: begin
                if (clk_stable) begin
                    nxt      = ST_EXIT_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = RC_LOAD;
                end
            end
            ST_EXIT_RECOVER: begin
                if (tmr_zero) begin
                    nxt      = ST_POST_REF_BURST;
                    ref_load = 1'b1;
                end
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        cmd       = CMD_NOP;
        cke_on    = 1'b1;
        enter_ack = 1'b0;
        exit_ack  = 1'b0;
        sr_active = 1'b0;
        sr_done   = 1'b0;
        unique case (cur)
            ST_IDLE: begin
                cmd = CMD_NOP;
            end
            ST_PRE_REF_BURST: begin
                cmd = (tmr_zero && !ref_empty) ? CMD_AREF : CMD_NOP;
            end
            ST_SR_ENTER: begin
                cmd       = CMD_SRE;
                cke_on    = 1'b0;
                enter_ack = 1'b1;
                sr_active = 1'b1;
            end
            ST_SR_HOLD, ST_WAIT_CLK: begin
                cmd       = CMD_DESEL;
                cke_on    = 1'b0;
                sr_active = 1'b1;
            end
            ST_EXIT_RECOVER: begin
                cmd       = CMD_DESEL;
                sr_active = 1'b1;
                exit_ack  = (tmr_count == RC_LOAD);
            end
            ST_POST_REF_BURST: begin
                cmd       = (tmr_zero && !ref_empty) ? CMD_AREF : CMD_NOP;
                sr_active = 1'b1;
            end
            ST_DONE: begin
                sr_done = 1'b1;
            end
        endcase
    end

    sr_cmd_encode u_enc (
        .cmd    (cmd),
        .cke_on (cke_on),
        .pins   (pins)
    );

    assign sdr_cs_n  = pins.cs_n;
    assign sdr_ras_n = pins.ras_n;
    assign sdr_cas_n = pins.cas_n;
    assign sdr_we_n  = pins.we_n;
    assign sdr_cke   = pins.cke;
    assign sdr_dqm   = pins.dqm;
endmodule

// File: rtl/sr_seq_checker.sv
module sr_seq_checker #(
    parameter int T_RC  = 7,
    parameter int T_RAS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic exit_req,
    input logic clk_stable,
    input logic enter_ack,
    input logic exit_ack,
    input logic sr_active,
    input logic sr_done,
    input logic sdr_cs_n,
    input logic sdr_ras_n,
    input logic sdr_cas_n,
    input logic sdr_we_n,
    input logic sdr_cke,
    input logic sdr_dqm
);
    localparam int LIM = ((T_RC > T_RAS) ? T_RC : T_RAS) + 1;
    localparam int CW  = $clog2(LIM + 1) + 1;

    logic [CW-1:0] low_cnt, high_cnt, aref_gap;
    logic          exit_seen;
    logic          aref_now;

    assign aref_now = sdr_cke && !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            high_cnt  <= CW'(LIM);
            aref_gap  <= CW'(LIM);
            exit_seen <= 1'b0;
        end else begin
            low_cnt  <= sdr_cke ? '0 : ((low_cnt < CW'(LIM)) ? low_cnt + 1'b1 : low_cnt);
            high_cnt <= !sdr_cke ? '0 : ((high_cnt < CW'(LIM)) ? high_cnt + 1'b1 : high_cnt);
            aref_gap <= aref_now ? CW'(1) : ((aref_gap < CW'(LIM)) ? aref_gap + 1'b1 : aref_gap);
            if (!sdr_cke && exit_req) begin
                exit_seen <= 1'b1;
            end else if (sdr_cke) begin
                exit_seen <= 1'b0;
            end
        end
    end

    AST_ENTRY_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke) |-> (!sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n && enter_ack)); // R1

    AST_ACK_ON_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        enter_ack |-> !sdr_cke); // R1

    AST_PARKED_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdr_cke && !enter_ack) |-> (sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n && sdr_dqm)); // R2

    AST_WAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke) |-> exit_seen); // R3

    AST_WAKE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke) |-> $past(clk_stable)); // R4

    AST_RECOVER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cke && high_cnt < CW'(T_RC)) |-> sdr_cs_n); // R5

    AST_EXIT_ACK_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ack |-> $rose(sdr_cke)); // R5

    AST_MIN_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke) |-> (low_cnt >= CW'(T_RAS))); // R6

    AST_AREF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        aref_now |-> (aref_gap >= CW'(T_RC))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_done |=> !sr_done); // R10

    AST_DONE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_done |-> !sr_active); // R10

    AST_ASLEEP_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cke |-> sr_active); // R10
endmodule

bind sdram_sr_seq sr_seq_checker #(.T_RC(T_RC), .T_RAS(T_RAS)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .exit_req   (exit_req),
    .clk_stable (clk_stable),
    .enter_ack  (enter_ack),
    .exit_ack   (exit_ack),
    .sr_active  (sr_active),
    .sr_done    (sr_done),
    .sdr_cs_n   (sdr_cs_n),
    .sdr_ras_n  (sdr_ras_n),
    .sdr_cas_n  (sdr_cas_n),
    .sdr_we_n   (sdr_we_n),
    .sdr_cke    (sdr_cke),
    .sdr_dqm    (sdr_dqm)
);

// File: tb/tb_sdram_sr_seq.sv
module tb_sdram_sr_seq;
    localparam int T_RC  = 7;
    localparam int T_RAS = 5;
    localparam int N_REF = 4;

    localparam int EV_AREF = 0;
    localparam int EV_SRE  = 1;
    localparam int EV_RISE = 2;
    localparam int EV_DONE = 3;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0;
    logic exit_req = 1'b0;
    logic clk_stable = 1'b1;
    logic enter_ack, exit_ack, sr_active, sr_done;
    logic sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_cke, sdr_dqm;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    bit   prev_cke = 1'b1;
    int   rise_at = -1000;
    exp_t expq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_sr_seq #(.T_RC(T_RC), .T_RAS(T_RAS), .REF_COUNT(N_REF)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .clk_stable (clk_stable),
        .enter_ack  (enter_ack),
        .exit_ack   (exit_ack),
        .sr_active  (sr_active),
        .sr_done    (sr_done),
        .sdr_cs_n   (sdr_cs_n),
        .sdr_ras_n  (sdr_ras_n),
        .sdr_cas_n  (sdr_cas_n),
        .sdr_we_n   (sdr_we_n),
        .sdr_cke    (sdr_cke),
        .sdr_dqm    (sdr_dqm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        expq.push_back(e);
    endtask

    // Monitor: classify events and compare against the expected queue
    always @(negedge clk) begin
        int kind;
        if (rst_n && mon_on) begin
            kind = -1;
            if (sdr_cke && !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n) kind = EV_AREF;
            else if (!sdr_cke && prev_cke) kind = EV_SRE;
            else if (sdr_cke && !prev_cke) kind = EV_RISE;
            else if (sr_done) kind = EV_DONE;

            if (kind == EV_SRE) begin
                chk(!sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n, "R1", "entry pins",
                    {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}, 1);
                chk(enter_ack, "R1", "enter_ack at entry", enter_ack, 1);
                chk(sr_active, "R10", "sr_active at entry", sr_active, 1);
            end else if (!sdr_cke) begin
                chk(sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n && sdr_dqm && sr_active,
                    "R2", "parked pins asleep",
                    {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_dqm, sr_active}, 63);
            end
            if (kind == EV_RISE) begin
                rise_at = cyc;
                chk(exit_ack, "R5", "exit_ack at rise", exit_ack, 1);
            end
            if (sdr_cke && (cyc - rise_at) < T_RC) begin
                chk(sdr_cs_n, "R5", "deselect during recovery", sdr_cs_n, 1);
            end
            if (kind == EV_DONE) begin
                chk(!sr_active, "R10", "sr_active at done", sr_active, 0);
            end
            if (kind >= 0) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", $sformatf("unexpected event kind %0d at cycle", kind), cyc, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(e.kind == kind && e.at == cyc, e.req,
                        $sformatf("event kind %0d (exp %0d) cycle", kind, e.kind), cyc, e.at);
                end
            end
            prev_cke = sdr_cke;
        end
    end

    // Driver: request entry, predict refresh burst and entry command
    task automatic do_enter(output int s);
        int p;
        @(negedge clk);
        p = cyc;
        enter_req = 1'b1;
        for (int i = 0; i < N_REF; i++) push(EV_AREF, p + 1 + i * T_RC, "R7");
        s = p + 2 + N_REF * T_RC;
        push(EV_SRE, s, "R8");
        @(negedge clk);
        enter_req = 1'b0;
        while (cyc < s + 1) @(negedge clk);
    endtask

    // Driver: request exit, predict rise, post burst and done
    task automatic do_exit(input int s, input int q_at, input bit stable_now,
                           input int stable_wait, input string rise_req);
        int q, wait_entry, rise, done_at;
        clk_stable = stable_now;
        while (cyc < q_at) @(negedge clk);
        q = cyc;
        exit_req = 1'b1;
        wait_entry = ((q > s + T_RAS) ? q : s + T_RAS) + 1;
        if (stable_now) begin
            rise = wait_entry + 1;
            push(EV_RISE, rise, rise_req);
        end else begin
            while (cyc < wait_entry + stable_wait) @(negedge clk);
            chk(!sdr_cke, "R4", "cke low before clk_stable", sdr_cke, 0);
            clk_stable = 1'b1;
            rise = cyc + 1;
            push(EV_RISE, rise, rise_req);
        end
        for (int i = 0; i < N_REF; i++) push(EV_AREF, rise + T_RC + i * T_RC, (i == 0) ? "R9" : "R7");
        done_at = rise + (N_REF + 1) * T_RC + 1;
        push(EV_DONE, done_at, "R10");
        while (cyc < rise) @(negedge clk);
        exit_req = 1'b0;
        while (cyc < done_at + 2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired at cycle", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(sdr_cke && !sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n && sdr_dqm,
            "R11", "pins in reset", {sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_dqm}, 47);
        chk(!enter_ack && !exit_ack && !sr_active && !sr_done, "R11", "status in reset",
            {enter_ack, exit_ack, sr_active, sr_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdr_cke && !sdr_cs_n && !sr_active, "R11", "idle after reset",
            {sdr_cke, sdr_cs_n, sr_active}, 4);
        mon_on = 1'b1;

        // R3: exit_req in IDLE is ignored
        exit_req = 1'b1;
        repeat (12) @(negedge clk);
        exit_req = 1'b0;
        chk(sdr_cke && !sr_active, "R3", "exit_req in idle ignored", {sdr_cke, sr_active}, 2);

        // Round A: long sleep, stray enter_req, late exit request
        do_enter(s);
        enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        repeat (60) @(negedge clk);
        chk(!sdr_cke, "R3", "cke held low without exit_req", sdr_cke, 0);
        chk(sdr_cs_n && sdr_dqm, "R2", "parked after long sleep", {sdr_cs_n, sdr_dqm}, 3);
        do_exit(s, cyc, 1'b1, 0, "R3");

        // Round B: exit requested at once, residency bound decides
        do_enter(s);
        do_exit(s, cyc, 1'b1, 0, "R6");

        // Round C: clock not stable when exit is taken
        do_enter(s);
        do_exit(s, s + 20, 1'b0, 15, "R4");

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R7", "expected events left", expq.size(), 0);
        chk(sdr_cke && !sr_active && !sdr_cs_n, "R10", "back in idle",
            {sdr_cke, sr_active, sdr_cs_n}, 4);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule